// File: doc/BRIEF.md
# Clock synthesizer divider configuration controller

This block keeps the divider settings of a programmable clock synthesizer: a 10-bit feedback divider, two output dividers and an output prescaler. It drives them to the PLL at all times. While the synchronous active-low reset is held, the block takes its settings from a set of parallel input pins. The values present in the last reset cycle remain in force after release.

After reset, software can read and change the settings through a small two-wire serial slave. The slave's SCL and SDA lines are oversampled by the core clock, and SDA is driven open-drain. A mode input decides whether serial writes take effect. When writes are locked, the slave still acknowledges every byte and still answers reads, but it changes nothing. Writing a command code to the command address loads a staged feedback value, or steps the active value up or down by one. No command is checked for range.

The output enable falls the moment reset is asserted, without waiting for a clock edge. It rises on the first clock edge after reset is released.

Top module: `synth_cfg_ctrl`

## Requirements
- R1: The 7-bit slave address is the fixed prefix 5'b11011 followed by `adr_sel[1:0]`. Bit 0 of the address byte selects a write (0) or a read (1). On a match the slave pulls SDA low during the ninth clock. On a mismatch it never pulls SDA low before the next START.
- R2: `out_en` goes low as soon as `rst_n` is low, without waiting for a clock edge. It is high from the first clock edge at which `rst_n` is high.
- R3: While `rst_n` is low, the feedback, output and prescaler dividers follow `par_m`, `par_na`, `par_nb` and `par_p` at every clock, and both limit registers clear. After release these values are held whatever the level of `wr_en`, and later changes on the parallel pins have no effect.
- R4: With `wr_en` high, a write consists of the address byte, a register pointer byte and then data bytes. The pointer advances by one, modulo 8, after each data byte. The register map is:
  - 0: staged M[7:0]
  - 1: staged M[9:8] in bits 1:0
  - 2: NA in bits 2:0 and NB in bits 6:4
  - 3: P in bits 1:0
  - 4: lower limit
  - 5: upper limit
  - 6: command
- R5: With `wr_en` low, the address and every data byte are still acknowledged, but no register and no output changes. This includes command writes.
- R6: A read returns the live configuration in either mode, starting at the current pointer:
  - 0 and 1: the active M (not the staged M)
  - 2: {1'b0, NB, 1'b0, NA}
  - 3: P
  - 4 and 5: the limits
  - 6 and 7: zero

  Each master acknowledge advances the pointer; a not-acknowledge ends the read.
- R7: Command 8'h01 copies the staged M to `fb_div`. Command 8'h02 adds one and command 8'h03 subtracts one, both modulo 1024. Any other code has no effect. No command alters the limit registers, and no range check is applied.
- R8: A value carried by a data byte appears on the divider outputs within five clock cycles after the SCL rising edge that samples the byte's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; also gates `out_en` directly |
| wr_en | input | 1 | 1: serial writes take effect; 0: writes are acknowledged and discarded |
| adr_sel | input | 2 | Low two bits of the slave address |
| par_m | input | 10 | Feedback divider captured during reset |
| par_na | input | N_W | Output divider A captured during reset |
| par_nb | input | N_W | Output divider B captured during reset |
| par_p | input | P_W | Prescaler captured during reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the open-drain SDA line low |
| fb_div | output | 10 | Active feedback divider to the PLL |
| na_div | output | N_W | Active output divider A |
| nb_div | output | N_W | Active output divider B |
| pre_div | output | P_W | Active prescaler |
| out_en | output | 1 | Output enable, low during reset |

## Verification
A corrupted divider register is visible on its output port at the very next clock edge. The bench compares all four divider outputs and the enable against its model on every clock while the bus is idle, so such a fault is caught within one clock. A wrong pointer or a wrong bus state shows only on the serial line: as a missing or spurious acknowledge, as a wrong read byte, or as a write landing on the wrong register. These faults surface at the end of the affected byte, one serial bit time later. A slow or missing command update is caught by a check placed five clocks after the last bit of the command byte.

// File: rtl/synth_cfg_pkg.sv
// Shared constants and types for the synthesizer configuration controller.
// Assumes an 8-bit register space addressed by a 3-bit pointer.
package synth_cfg_pkg;
    localparam int PTR_W = 3;

    localparam logic [PTR_W-1:0] RA_MLO  = 3'd0;
    localparam logic [PTR_W-1:0] RA_MHI  = 3'd1;
    localparam logic [PTR_W-1:0] RA_NDIV = 3'd2;
    localparam logic [PTR_W-1:0] RA_PRE  = 3'd3;
    localparam logic [PTR_W-1:0] RA_LO   = 3'd4;
    localparam logic [PTR_W-1:0] RA_HI   = 3'd5;
    localparam logic [PTR_W-1:0] RA_CMD  = 3'd6;

    localparam logic [7:0] CMD_LOAD = 8'h01;
    localparam logic [7:0] CMD_INC  = 8'h02;
    localparam logic [7:0] CMD_DEC  = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDAT,
        ST_TX,
        ST_MACK
    } bus_state_t;
endpackage

// File: rtl/synth_cfg_sync.sv
// Two-flop synchroniser with edge detection for W asynchronous lines.
// Assumes the lines idle high (open-drain bus), so reset loads ones.
module synth_cfg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, prev_q;

    // Purpose: resynchronise the lines and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '1;
            s2_q   <= '1;
            prev_q <= '1;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Purpose: expose the level and the single-cycle edge strobes.
    always_comb begin
        lvl  = s2_q;
        rise = s2_q & ~prev_q;
        fall = ~s2_q & prev_q;
    end
endmodule

// File: rtl/synth_cfg_i2c.sv
// Byte-level two-wire slave: START/STOP detection, address match,
// pointer and data reception, and read transmission with master acknowledge.
// Assumes the core clock is at least 8x faster than SCL and that SDA only
// changes while SCL is low, apart from START and STOP.
module synth_cfg_i2c
    import synth_cfg_pkg::*;
#(
    parameter logic [4:0] ADDR_PFX = 5'b11011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       adr_sel,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [7:0]       rd_byte,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             wr_stb,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [7:0]       wr_byte,
    output logic             sda_pull
);
    bus_state_t       st_q;
    logic [7:0]       sh_q;
    logic [3:0]       cnt_q;
    logic             rw_q, ack_pend_q, in_ack_q, mack_ok_q;
    logic [PTR_W-1:0] ptr_q;
    logic             start_c, stop_c;
    logic [7:0]       nb_c;

    // Purpose: decode bus conditions and the byte completed by this SCL rise.
    always_comb begin
        start_c = sda_fall & scl_lvl;
        stop_c  = sda_rise & scl_lvl;
        nb_c    = {sh_q[6:0], sda_lvl};
        rd_ptr  = ptr_q;
    end

    // Purpose: sequence the bus protocol on the synchronised SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            sh_q       <= '0;
            cnt_q      <= '0;
            rw_q       <= 1'b0;
            ack_pend_q <= 1'b0;
            in_ack_q   <= 1'b0;
            mack_ok_q  <= 1'b0;
            ptr_q      <= '0;
            wr_stb     <= 1'b0;
            wr_ptr     <= '0;
            wr_byte    <= '0;
            sda_pull   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (start_c || stop_c) begin
                st_q       <= start_c ? ST_ADDR : ST_IDLE;
                cnt_q      <= '0;
                ack_pend_q <= 1'b0;
                in_ack_q   <= 1'b0;
                sda_pull   <= 1'b0;
            end else if (scl_rise) begin
                case (st_q)
                    ST_ADDR, ST_PTR, ST_WDAT: begin
                        if (!in_ack_q) begin
                            sh_q  <= nb_c;
                            cnt_q <= cnt_q + 4'd1;
                            if (cnt_q == 4'd7) begin
                                if (st_q == ST_ADDR) begin
                                    if (nb_c[7:1] == {ADDR_PFX, adr_sel}) begin
                                        ack_pend_q <= 1'b1;
                                        rw_q       <= nb_c[0];
                                    end else begin
                                        st_q <= ST_IDLE;
                                    end
                                end else if (st_q == ST_PTR) begin
                                    ptr_q      <= nb_c[PTR_W-1:0];
                                    ack_pend_q <= 1'b1;
                                end else begin
                                    wr_stb     <= 1'b1;
                                    wr_ptr     <= ptr_q;
                                    wr_byte    <= nb_c;
                                    ptr_q      <= ptr_q + 1'b1;
                                    ack_pend_q <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_TX:   cnt_q <= cnt_q + 4'd1;
                    ST_MACK: begin
                        mack_ok_q <= !sda_lvl;
                        if (!sda_lvl) ptr_q <= ptr_q + 1'b1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                if (ack_pend_q) begin
                    sda_pull   <= 1'b1;
                    ack_pend_q <= 1'b0;
                    in_ack_q   <= 1'b1;
                    cnt_q      <= '0;
                end else if (in_ack_q) begin
                    in_ack_q <= 1'b0;
                    sda_pull <= 1'b0;
                    if (st_q == ST_ADDR && rw_q) begin
                        st_q     <= ST_TX;
                        sh_q     <= rd_byte;
                        sda_pull <= ~rd_byte[7];
                        cnt_q    <= '0;
                    end else if (st_q == ST_ADDR) begin
                        st_q <= ST_PTR;
                    end else if (st_q == ST_PTR) begin
                        st_q <= ST_WDAT;
                    end
                end else if (st_q == ST_TX) begin
                    if (cnt_q == 4'd8) begin
                        sda_pull <= 1'b0;
                        st_q     <= ST_MACK;
                    end else begin
                        sh_q     <= {sh_q[6:0], 1'b0};
                        sda_pull <= ~sh_q[6];
                    end
                end else if (st_q == ST_MACK) begin
                    if (mack_ok_q) begin
                        st_q     <= ST_TX;
                        sh_q     <= rd_byte;
                        sda_pull <= ~rd_byte[7];
                        cnt_q    <= '0;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
            end
        end
    end

    // R1: an idle slave never holds the data line.
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_pull);

    // R1: an acknowledge is only pulled after a completed byte.
    assert_ack_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_ack_q)) |-> $past(ack_pend_q));
endmodule

// File: rtl/synth_cfg_regs.sv
// Configuration register file: parallel capture in reset, gated serial
// writes, command execution on the feedback divider and the read mux.
// Assumes N_W <= 4 so both output dividers share one byte.
module synth_cfg_regs
    import synth_cfg_pkg::*;
#(
    parameter int M_W   = 10,
    parameter int N_W   = 3,
    parameter int P_W   = 2,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [M_W-1:0]   par_m,
    input  logic [N_W-1:0]   par_na,
    input  logic [N_W-1:0]   par_nb,
    input  logic [P_W-1:0]   par_p,
    input  logic             wr_stb,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [7:0]       wr_byte,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [7:0]       rd_byte,
    output logic [M_W-1:0]   fb_div,
    output logic [N_W-1:0]   na_div,
    output logic [N_W-1:0]   nb_div,
    output logic [P_W-1:0]   pre_div
);
    localparam int MHI_W = M_W - 8;

    logic [M_W-1:0]   stage_q;
    logic [LIM_W-1:0] lo_q, hi_q;
    logic             do_wr, is_cmd;

    // Purpose: qualify serial writes with the write-enable mode.
    always_comb begin
        do_wr  = wr_stb && wr_en;
        is_cmd = do_wr && (wr_ptr == RA_CMD);
    end

    // Purpose: capture the parallel pins in reset, then apply serial writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_div  <= par_m;
            stage_q <= par_m;
            na_div  <= par_na;
            nb_div  <= par_nb;
            pre_div <= par_p;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (do_wr) begin
            case (wr_ptr)
                RA_MLO:  stage_q[7:0]   <= wr_byte;
                RA_MHI:  stage_q[M_W-1:8] <= wr_byte[MHI_W-1:0];
                RA_NDIV: begin
                    na_div <= wr_byte[N_W-1:0];
                    nb_div <= wr_byte[4 +: N_W];
                end
                RA_PRE:  pre_div <= wr_byte[P_W-1:0];
                RA_LO:   lo_q    <= wr_byte[LIM_W-1:0];
                RA_HI:   hi_q    <= wr_byte[LIM_W-1:0];
                RA_CMD: begin
                    if (wr_byte == CMD_LOAD)     fb_div <= stage_q;
                    else if (wr_byte == CMD_INC) fb_div <= fb_div + 1'b1;
                    else if (wr_byte == CMD_DEC) fb_div <= fb_div - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Purpose: present the live configuration at the read pointer.
    always_comb begin
        rd_byte = '0;
        case (rd_ptr)
            RA_MLO:  rd_byte = fb_div[7:0];
            RA_MHI:  rd_byte[MHI_W-1:0] = fb_div[M_W-1:8];
            RA_NDIV: begin
                rd_byte[N_W-1:0]  = na_div;
                rd_byte[4 +: N_W] = nb_div;
            end
            RA_PRE:  rd_byte[P_W-1:0]   = pre_div;
            RA_LO:   rd_byte[LIM_W-1:0] = lo_q;
            RA_HI:   rd_byte[LIM_W-1:0] = hi_q;
            default: rd_byte = '0;
        endcase
    end

    // R5: a write while locked leaves every register unchanged.
    assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_en) |=> ($stable(fb_div) && $stable(na_div) && $stable(nb_div)
                                && $stable(pre_div) && $stable(lo_q) && $stable(hi_q)));

    // R7: the increment command steps the feedback divider by one, wrapping.
    assert_inc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && wr_byte == CMD_INC) |=> (fb_div == M_W'($past(fb_div) + 1'b1)));

    // R7: the decrement command steps the feedback divider down by one, wrapping.
    assert_dec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && wr_byte == CMD_DEC) |=> (fb_div == M_W'($past(fb_div) - 1'b1)));

    // R7: no command touches the limit registers.
    assert_limits_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/synth_cfg_ctrl.sv
// Top level: synchronises the bus lines, runs the serial slave, holds the
// divider registers and drives the output enable.
// Assumes clk is at least 8x the SCL rate; rst_n is synchronous for state
// but gates out_en combinationally so it drops without a clock.
module synth_cfg_ctrl
    import synth_cfg_pkg::*;
#(
    parameter logic [4:0] ADDR_PFX = 5'b11011,
    parameter int         N_W      = 3,
    parameter int         P_W      = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     adr_sel,
    input  logic [9:0]     par_m,
    input  logic [N_W-1:0] par_na,
    input  logic [N_W-1:0] par_nb,
    input  logic [P_W-1:0] par_p,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic           sda_pull,
    output logic [9:0]     fb_div,
    output logic [N_W-1:0] na_div,
    output logic [N_W-1:0] nb_div,
    output logic [P_W-1:0] pre_div,
    output logic           out_en
);
    localparam int LINE_SCL = 1;
    localparam int LINE_SDA = 0;

    logic [1:0]       lvl, rise, fall;
    logic [7:0]       rd_byte, wr_byte;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             wr_stb, en_q;

    synth_cfg_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    synth_cfg_i2c #(.ADDR_PFX(ADDR_PFX)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .adr_sel (adr_sel),
        .scl_lvl (lvl[LINE_SCL]),
        .scl_rise(rise[LINE_SCL]),
        .scl_fall(fall[LINE_SCL]),
        .sda_lvl (lvl[LINE_SDA]),
        .sda_rise(rise[LINE_SDA]),
        .sda_fall(fall[LINE_SDA]),
        .rd_byte (rd_byte),
        .rd_ptr  (rd_ptr),
        .wr_stb  (wr_stb),
        .wr_ptr  (wr_ptr),
        .wr_byte (wr_byte),
        .sda_pull(sda_pull)
    );

    synth_cfg_regs #(.M_W(10), .N_W(N_W), .P_W(P_W), .LIM_W(8)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .par_m  (par_m),
        .par_na (par_na),
        .par_nb (par_nb),
        .par_p  (par_p),
        .wr_stb (wr_stb),
        .wr_ptr (wr_ptr),
        .wr_byte(wr_byte),
        .rd_ptr (rd_ptr),
        .rd_byte(rd_byte),
        .fb_div (fb_div),
        .na_div (na_div),
        .nb_div (nb_div),
        .pre_div(pre_div)
    );

    // Purpose: raise the enable one clock after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= 1'b1;
    end

    // Purpose: force the enable low at once while reset is asserted.
    always_comb out_en = en_q & rst_n;

    // R2: the first clock after reset release still shows the enable low,
    // and it is high from the next one.
    assert_enable_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_en ##1 out_en));
endmodule

// File: tb/test_synth_cfg_ctrl.sv
`timescale 1ns/100ps
module test_synth_cfg_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] adr_sel = 2'b01;
    logic [9:0] par_m = '0;
    logic [2:0] par_na = '0, par_nb = '0;
    logic [1:0] par_p = '0;
    logic       scl = 1'b1, m_low = 1'b0;
    logic       sda_pull, out_en;
    logic [9:0] fb_div;
    logic [2:0] na_div, nb_div;
    logic [1:0] pre_div;
    wire        sda = ~(m_low | sda_pull);

    int checks = 0, errors = 0;
    bit cmp_en = 1'b0;
    // reference model
    int em, estage, ena, enb, ep, elo, ehi;

    localparam logic [7:0] AW = 8'hDA; // {11011,01,0}
    localparam logic [7:0] AR = 8'hDB;

    always #2.5 clk = ~clk;

    synth_cfg_ctrl i_synth_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .adr_sel(adr_sel),
        .par_m(par_m), .par_na(par_na), .par_nb(par_nb), .par_p(par_p),
        .scl_in(scl), .sda_in(sda), .sda_pull(sda_pull),
        .fb_div(fb_div), .na_div(na_div), .nb_div(nb_div), .pre_div(pre_div),
        .out_en(out_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock comparison against the model while the bus is idle
    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            check(fb_div == em[9:0], "R7 fb_div per-clock", fb_div, em);
            check(na_div == ena[2:0] && nb_div == enb[2:0], "R4 n-div per-clock",
                  {nb_div, na_div}, {enb[2:0], ena[2:0]});
            check(pre_div == ep[1:0], "R4 pre_div per-clock", pre_div, ep);
            check(out_en == 1'b1, "R2 out_en per-clock", out_en, 1);
        end
    end

    function automatic logic [7:0] img(input int a);
        case (a)
            0: img = em[7:0];
            1: img = {6'b0, em[9:8]};
            2: img = {1'b0, enb[2:0], 1'b0, ena[2:0]};
            3: img = {6'b0, ep[1:0]};
            4: img = elo[7:0];
            5: img = ehi[7:0];
            default: img = 8'h00;
        endcase
    endfunction

    task automatic bstart();
        m_low = 1'b0; tick(6); scl = 1'b1; tick(6); m_low = 1'b1; tick(6); scl = 1'b0; tick(6);
    endtask

    task automatic bstop();
        m_low = 1'b1; tick(6); scl = 1'b1; tick(6); m_low = 1'b0; tick(6);
    endtask

    task automatic send(input logic [7:0] b, input bit chk, input logic [9:0] expm, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(6); scl = 1'b1;
            if (chk && i == 0) begin
                tick(5);
                check(fb_div == expm, "R8 command latency", fb_div, expm);
                tick(1);
            end else tick(6);
            scl = 1'b0;
        end
        m_low = 1'b0; tick(6); scl = 1'b1; tick(3); ack = ~sda; tick(3); scl = 1'b0; tick(6);
    endtask

    task automatic recv(input bit mack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(6); scl = 1'b1; tick(3); b[i] = sda; tick(3); scl = 1'b0;
        end
        m_low = mack; tick(6); scl = 1'b1; tick(6); scl = 1'b0; m_low = 1'b0;
    endtask

    task automatic wr_regs(input logic [2:0] ptr, input logic [7:0] d [4], input int n,
                           input bit chk, input logic [9:0] expm, input string tag);
        bit a;
        cmp_en = 1'b0;
        bstart();
        send(AW, 1'b0, '0, a);  check(a, "R1 address ack (write)", a, 1);
        send({5'b0, ptr}, 1'b0, '0, a); check(a, {tag, " pointer ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            send(d[k], chk && (k == n - 1), expm, a);
            check(a, {tag, " data ack"}, a, 1);
        end
        bstop(); tick(6);
        cmp_en = 1'b1;
    endtask

    task automatic rd_regs(input logic [2:0] ptr, input int n, input string tag);
        bit a;
        logic [7:0] q;
        cmp_en = 1'b0;
        bstart();
        send(AW, 1'b0, '0, a); check(a, "R1 address ack", a, 1);
        send({5'b0, ptr}, 1'b0, '0, a); check(a, "R6 pointer ack", a, 1);
        bstart();
        send(AR, 1'b0, '0, a); check(a, "R1 address ack (read)", a, 1);
        for (int k = 0; k < n; k++) begin
            recv(k != n - 1, q);
            check(q == img((ptr + k) % 8), tag, q, img((ptr + k) % 8));
        end
        bstop(); tick(6);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit a;
        // ---- reset capture (R3) and enable (R2)
        par_m = 10'h155; par_na = 3'd3; par_nb = 3'd5; par_p = 2'd2;
        tick(4);
        check(out_en == 1'b0, "R2 out_en low in reset", out_en, 0);
        par_m = 10'h2AA;
        tick(3);
        rst_n = 1'b1;
        par_m = 10'h0AA; par_na = 3'd0; par_nb = 3'd0; par_p = 2'd0;
        em = 'h2AA; estage = 'h2AA; ena = 3; enb = 5; ep = 2; elo = 0; ehi = 0;
        #1 check(out_en == 1'b0, "R2 out_en low before first clock", out_en, 0);
        tick(1);
        check(out_en == 1'b1, "R2 out_en high after release", out_en, 1);
        check(fb_div == 10'h2AA, "R3 fb_div captured at release", fb_div, 'h2AA);
        cmp_en = 1'b1;
        tick(5);

        // ---- locked mode: acknowledged but discarded (R5), reads work (R6)
        wr_regs(3'd2, '{8'h61, 8'h01, 8'h40, 8'h7F}, 4, 1'b0, '0, "R5 locked");
        wr_regs(3'd6, '{8'h02, 8'h00, 8'h00, 8'h00}, 1, 1'b0, '0, "R5 locked command");
        check(fb_div == 10'h2AA, "R5 command ignored while locked", fb_div, 'h2AA);
        rd_regs(3'd0, 6, "R6 read while locked");

        // ---- unlocked writes with pointer auto-increment (R4)
        wr_en = 1'b1;
        ena = 1; enb = 6; ep = 1; elo = 'h40; ehi = 'h7F;
        wr_regs(3'd2, '{8'h61, 8'h01, 8'h40, 8'h7F}, 4, 1'b0, '0, "R4 write");
        check(na_div == 3'd1 && nb_div == 3'd6, "R4 n-div fields", {nb_div, na_div}, 'h31);
        rd_regs(3'd2, 4, "R6 read back");
        rd_regs(3'd6, 3, "R6 read wraps pointer");

        // ---- mismatched address gets no acknowledge (R1)
        adr_sel = 2'b10;
        cmp_en = 1'b0;
        bstart();
        send(AW, 1'b0, '0, a);
        check(!a, "R1 mismatch not acknowledged", a, 0);
        send(8'h06, 1'b0, '0, a);
        check(!a, "R1 silent until next START", a, 0);
        bstop(); tick(6); cmp_en = 1'b1;
        adr_sel = 2'b01;

        // ---- staging, LOAD, INC/DEC wrap, unknown code (R7, R8)
        estage = 'h3FF;
        wr_regs(3'd0, '{8'hFF, 8'h03, 8'h00, 8'h00}, 2, 1'b0, '0, "R4 stage M");
        check(fb_div == 10'h2AA, "R7 staging leaves fb_div", fb_div, 'h2AA);
        em = 'h3FF;
        wr_regs(3'd6, '{8'h01, 8'h00, 8'h00, 8'h00}, 1, 1'b1, 10'h3FF, "R7 LOAD");
        em = 'h000;
        wr_regs(3'd6, '{8'h02, 8'h00, 8'h00, 8'h00}, 1, 1'b1, 10'h000, "R7 INC wrap");
        em = 'h3FF;
        wr_regs(3'd6, '{8'h03, 8'h00, 8'h00, 8'h00}, 1, 1'b1, 10'h3FF, "R7 DEC wrap");
        wr_regs(3'd6, '{8'h07, 8'h00, 8'h00, 8'h00}, 1, 1'b1, 10'h3FF, "R7 unknown code");
        rd_regs(3'd0, 6, "R7 limits untouched by commands");

        // ---- reset again with writes enabled (R3, R2)
        cmp_en = 1'b0;
        par_m = 10'h123; par_na = 3'd7; par_nb = 3'd0; par_p = 2'd3;
        rst_n = 1'b0;
        #1 check(out_en == 1'b0, "R2 out_en drops without clock", out_en, 0);
        tick(3);
        rst_n = 1'b1;
        em = 'h123; ena = 7; enb = 0; ep = 3; elo = 0; ehi = 0;
        tick(2);
        par_m = 10'h001;
        tick(2);
        check(fb_div == 10'h123, "R3 capture independent of wr_en", fb_div, 'h123);
        cmp_en = 1'b1;
        rd_regs(3'd0, 6, "R3 limits cleared by reset");
        tick(10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule